// File: doc/BRIEF.md
# DSP Late-Frame Stereo Serializer

This block puts a stereo PCM sample pair onto a single serial data line using late-aligned DSP framing. An outside source supplies the bit clock and a frame-sync pulse. Both are treated as level inputs that are synchronous to the block's system clock `clk`. The block finds bit-clock falling edges by comparing the current level with the level held from the previous `clk` cycle. A frame starts on the falling bit-clock edge at which the frame sync reads high, provided it read low at the previous falling edge.

Software or an upstream datapath writes a left/right pair into a holding stage with a one-cycle load strobe. At each frame start the held pair is copied into the shift stage. The left word goes out MSB first, beginning on the falling edge of the frame start itself, so a receiver can capture that MSB on the next rising edge. The right word follows with no gap. The line is then held low until the next frame start. If no new pair arrived since the previous frame start, the old pair is sent again and a sticky underrun flag is raised.

Top module: `dsp_late_serializer`

## Requirements
- R1: The left word's MSB appears on `sdo` in the `clk` cycle after the bit-clock falling edge on which the frame sync is seen rising, so it is valid at the next bit-clock rising edge.
- R2: `sdo` changes only in the `clk` cycle that follows a detected bit-clock falling edge, so it is stable across every bit-clock high phase.
- R3: The right word's MSB is driven on the falling edge directly after the left word's LSB, with no filler bit between them.
- R4: Each word is sent MSB first with n bits, where `wl_sel` 0/1/2/3 selects n = 16/20/24/32, and the word is taken from the upper n bits of the 32-bit input.
- R5: After the right word's LSB, `sdo` is driven low on every falling edge until the next frame start.
- R6: A pair loaded during a frame does not alter the bits of that frame, and it is the pair sent in the next frame.
- R7: If no pair was loaded between two frame starts, the second frame resends the previous pair and `underrun` goes high and stays high until reset.
- R8: While `rst_n` is low and right after it, `sdo` and `underrun` are both 0.
- R9: `wl_sel` is sampled only at frame start, so a change in mid-frame leaves that frame's word length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bit clock and frame sync are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock level |
| lrc | input | 1 | Frame-sync level |
| ld_stb | input | 1 | One-cycle strobe that writes a sample pair into the holding stage |
| ld_left | input | DW | Left sample; upper bits are used for short words |
| ld_right | input | DW | Right sample; upper bits are used for short words |
| wl_sel | input | 2 | Word length select: 0=16, 1=20, 2=24, 3=32 bits |
| sdo | output | 1 | Serial data output |
| underrun | output | 1 | Sticky flag: a frame started with no fresh pair |

## Verification
Every `sdo` update is due in the first `clk` cycle after the bit-clock falling edge that causes it. The bench changes the bit clock half a `clk` period away from the active edge and holds each half-bit for four `clk` cycles. The monitor reads the line at the bit-clock rising edge and reads it again just before the next fall, so a bit that arrives late or changes while the bit clock is high fails the comparison. The underrun flag changes one `clk` cycle after a frame start and is read at the end of each frame.

// File: rtl/dsp_ser_pkg.sv
package dsp_ser_pkg;
   localparam int MIN_DW = 32;

   // word length in bits for each select code
   function automatic int wl_bits(input int sel);
      case (sel)
         0:       return 16;
         1:       return 20;
         2:       return 24;
         default: return 32;
      endcase
   endfunction
endpackage

// File: rtl/dsp_ser_edge.sv
module dsp_ser_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   input  logic lrc,
   output logic fall,
   output logic start
);
   logic bclk_d;
   logic lrc_at_fall;

   assign fall  = bclk_d & ~bclk;
   assign start = fall & lrc & ~lrc_at_fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bclk_d      <= 1'b1;
         lrc_at_fall <= 1'b0;
      end else begin
         bclk_d <= bclk;
         if (fall) lrc_at_fall <= lrc;
      end
   end
endmodule

// File: rtl/dsp_ser_hold.sv
module dsp_ser_hold #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_stb,
   input  logic [DW-1:0] ld_left,
   input  logic [DW-1:0] ld_right,
   input  logic          start,
   output logic [DW-1:0] hold_l,
   output logic [DW-1:0] hold_r,
   output logic          underrun
);
   logic fresh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_l   <= '0;
         hold_r   <= '0;
         fresh    <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (start && !fresh) underrun <= 1'b1;
         if (ld_stb) begin
            hold_l <= ld_left;
            hold_r <= ld_right;
            fresh  <= 1'b1;
         end else if (start) begin
            fresh  <= 1'b0;
         end
      end
   end

   AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun); // R7
   AST_STALE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !fresh) |=> underrun); // R7
endmodule

// File: rtl/dsp_ser_shift.sv
module dsp_ser_shift #(
   parameter int DW = 32,
   parameter int CW = $clog2(DW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fall,
   input  logic          start,
   input  logic [DW-1:0] new_l,
   input  logic [DW-1:0] new_r,
   input  logic [CW-1:0] wlen,
   output logic          sdo
);
   logic [DW-1:0] sh_l;
   logic [DW-1:0] sh_r;
   logic [CW-1:0] rem_l;
   logic [CW-1:0] rem_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_l  <= '0;
         sh_r  <= '0;
         rem_l <= '0;
         rem_r <= '0;
         sdo   <= 1'b0;
      end else if (start) begin
         sdo   <= new_l[DW-1];
         sh_l  <= new_l << 1;
         sh_r  <= new_r;
         rem_l <= wlen - CW'(1);
         rem_r <= wlen;
      end else if (fall) begin
         if (rem_l != '0) begin
            sdo   <= sh_l[DW-1];
            sh_l  <= sh_l << 1;
            rem_l <= rem_l - CW'(1);
         end else if (rem_r != '0) begin
            sdo   <= sh_r[DW-1];
            sh_r  <= sh_r << 1;
            rem_r <= rem_r - CW'(1);
         end else begin
            sdo   <= 1'b0;
         end
      end
   end

   AST_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> $stable(sdo)); // R2
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !start && rem_l == '0 && rem_r == '0) |=> !sdo); // R5
   AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !start && rem_l == '0 && rem_r != '0) |=> (rem_r == $past(rem_r) - CW'(1))); // R3
endmodule

// File: rtl/dsp_late_serializer.sv
module dsp_late_serializer #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bclk,
   input  logic          lrc,
   input  logic          ld_stb,
   input  logic [DW-1:0] ld_left,
   input  logic [DW-1:0] ld_right,
   input  logic [1:0]    wl_sel,
   output logic          sdo,
   output logic          underrun
);
   import dsp_ser_pkg::*;

   localparam int CW = $clog2(DW + 1);
   localparam int NSEL = 4;

   generate
      if (DW < MIN_DW) begin : g_bad_dw
         $error("DW must be at least 32");
      end
   endgenerate

   logic          fall;
   logic          start;
   logic [DW-1:0] hold_l;
   logic [DW-1:0] hold_r;
   logic [CW-1:0] wl_opt [NSEL];
   logic [CW-1:0] wlen;

   for (genvar g = 0; g < NSEL; g++) begin : g_wl
      assign wl_opt[g] = CW'(wl_bits(g));
   end
   assign wlen = wl_opt[wl_sel];

   dsp_ser_edge i_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .bclk  (bclk),
      .lrc   (lrc),
      .fall  (fall),
      .start (start)
   );

   dsp_ser_hold #(.DW(DW)) i_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_stb   (ld_stb),
      .ld_left  (ld_left),
      .ld_right (ld_right),
      .start    (start),
      .hold_l   (hold_l),
      .hold_r   (hold_r),
      .underrun (underrun)
   );

   dsp_ser_shift #(.DW(DW), .CW(CW)) i_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .fall  (fall),
      .start (start),
      .new_l (hold_l),
      .new_r (hold_r),
      .wlen  (wlen),
      .sdo   (sdo)
   );

   AST_START_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (sdo == $past(hold_l[DW-1]))); // R1
endmodule

// File: tb/test_dsp_late_serializer.sv
module test_dsp_late_serializer;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_BIT   = 4;
   localparam int FRAME_BITS = 72;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b1;
   logic        lrc = 1'b0;
   logic        ld_stb = 1'b0;
   logic [31:0] ld_left = '0;
   logic [31:0] ld_right = '0;
   logic [1:0]  wl_sel = 2'd3;
   logic        sdo;
   logic        underrun;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct { logic val; string req; } exp_t;
   exp_t exp_q[$];
   logic last_val;
   string last_req;

   logic [31:0] m_hold_l = '0, m_hold_r = '0;
   bit m_fresh = 1'b0, m_under = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dsp_late_serializer i_dsp_late_serializer (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrc(lrc), .ld_stb(ld_stb),
      .ld_left(ld_left), .ld_right(ld_right), .wl_sel(wl_sel),
      .sdo(sdo), .underrun(underrun));

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // monitor: pops one expected bit at each bit-clock rising edge
   always @(posedge bclk) begin
      if (exp_q.size() == 0) begin
         checks++; errors++;
         $display("FAIL R2 actual=bit expected=none");
      end else begin
         exp_t e;
         e = exp_q.pop_front();
         last_val = e.val;
         last_req = e.req;
         check(e.req, sdo, e.val);
      end
   end

   task automatic load_pair(input logic [31:0] l, input logic [31:0] r);
      @(negedge clk);
      ld_left = l; ld_right = r; ld_stb = 1'b1;
      @(negedge clk);
      ld_stb = 1'b0;
      m_hold_l = l; m_hold_r = r; m_fresh = 1'b1;
   endtask

   // driver: queue expected bits for one frame, then clock it out
   task automatic run_frame(input logic [1:0] wl, input bit mid_load,
                            input logic [31:0] ml, input logic [31:0] mr,
                            input logic [1:0] mid_wl);
      int n;
      n = (wl == 0) ? 16 : (wl == 1) ? 20 : (wl == 2) ? 24 : 32;
      wl_sel = wl;
      if (!m_fresh) m_under = 1'b1;
      m_fresh = 1'b0;
      for (int k = 0; k < FRAME_BITS; k++) begin
         exp_t e;
         if (k < n) begin
            e.val = m_hold_l[31-k];
            e.req = (k == 0) ? "R1" : "R4";
         end else if (k < 2*n) begin
            e.val = m_hold_r[31-(k-n)];
            e.req = (k == n) ? "R3" : "R4";
         end else begin
            e.val = 1'b0;
            e.req = "R5";
         end
         exp_q.push_back(e);
      end
      for (int k = 0; k < FRAME_BITS; k++) begin
         @(negedge clk);
         bclk = 1'b0;
         if (k == 0) lrc = 1'b1;
         if (k == 1) lrc = 1'b0;
         if (k == 10 && mid_load) begin
            @(negedge clk);
            ld_left = ml; ld_right = mr; ld_stb = 1'b1;
            wl_sel = mid_wl; // R9: ignored until next frame start
            @(negedge clk);
            ld_stb = 1'b0;
            m_hold_l = ml; m_hold_r = mr; m_fresh = 1'b1; // R6
            repeat (HALF_BIT - 2) @(negedge clk);
         end else begin
            repeat (HALF_BIT) @(negedge clk);
         end
         bclk = 1'b1;
         repeat (HALF_BIT - 1) @(negedge clk);
         // R2: the bit must still hold just before the next fall
         check({last_req, "/R2"}, sdo, last_val);
         if (k == FRAME_BITS - 1) ;
      end
      check("R7", underrun, m_under);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R8", sdo, 1'b0);
      check("R8", underrun, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", sdo, 1'b0);

      load_pair(32'hA5A5_1234, 32'h0F0F_8001);
      run_frame(2'd3, 1'b0, '0, '0, 2'd0);                       // R4 32-bit
      load_pair(32'h8765_4321, 32'hFEDC_BA98);
      run_frame(2'd0, 1'b1, 32'h1357_9BDF, 32'hC0DE_F00D, 2'd3); // R6 R9
      run_frame(2'd1, 1'b0, '0, '0, 2'd0);                       // R4 20-bit
      run_frame(2'd2, 1'b0, '0, '0, 2'd0);                       // R7 repeat
      load_pair(32'h0000_0001, 32'h8000_0000);
      run_frame(2'd3, 1'b0, '0, '0, 2'd0);                       // R7 sticky
      check("R7", underrun, 1'b1);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule